// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block sequences reads for a 16-bit memory that serves data in bursts. A 16-bit configuration word sets the access style: initial latency, how many clocks each word is held, burst length, whether addresses wrap inside an aligned window, and the polarity and timing of a WAIT indication. When the active-low address strobe is sampled low, the engine captures the starting address and the configuration. After the programmed latency it steps through word addresses on a read port into an array model. It presents each returned word on the data bus along with a valid strobe.

While a burst runs, WAIT tells the host when no fresh word will follow. It is raised during the initial latency. When the latency code is above 4 and each word is held for one clock, it is also raised during the periodic gaps that follow every fourth word. WAIT can lead the data by one word period, and its active level is programmable. A strobe that arrives during a burst cancels that burst and begins a new one. A configuration that is illegal or unsupported raises an error flag, and the engine will not start while the flag is set. Page mode, which is selected by bit 15 and is the reset default, leaves the engine idle.

Top module: `sync_burst_reader`

## Requirements
- R1: After reset, `busy`, `dvalid` and `cfg_err` read 0 and `dout` reads zero. WAIT is at its inactive level, which is the inverse of live `cfg_word[10]`.
- R2: A strobe (`adv_n` low at a rising edge) while `cfg_word[15]`=1 starts nothing and leaves `busy` at 0. If a burst is running, that strobe ends it.
- R3: A strobe with a legal configuration and bit 15 clear sets `busy` from the next cycle. With latency code L in `cfg_word[13:11]`, counting that next cycle as cycle 1, the first word appears with `dvalid`=1 in cycle L.
- R4: `cfg_word[9]`=0 holds each word on `dout` for one cycle, and 1 holds it for two. `dout` equals the read-port data at `mem_addr` while `dvalid`=1, and reads zero otherwise.
- R5: `cfg_word[2:0]` sets the burst length: 001 is 4 words, 010 is 8, 011 is 16, and 111 is unbounded. A bounded burst drops `busy` in the cycle after the final hold cycle of its last word.
- R6: With `cfg_word[3]`=0 and a bounded length N, word i is read from (start & ~(N-1)) | ((start+i) & (N-1)). With bit 3 set, or with an unbounded length, word i is read from start+i, modulo 2^AW.
- R7: With one-cycle hold and L > 4, L-4 stall cycles follow each fourth word of the burst, unless that word is the last. With two-cycle hold, no stall cycles follow any word.
- R8: `cfg_word[10]`=1 drives WAIT high when active, and 0 drives it low when active. While busy, the level captured at the strobe is used.
- R9: WAIT is active in busy cycle t exactly when cycle t+D is a latency or stall cycle. D is 0 when `cfg_word[8]`=0, and D is the hold count (1 or 2) when bit 8 is 1.
- R10: `cfg_err` is 1 in any of these cases: latency code 0 or 1; a length code other than 001, 010, 011 or 111; bit 7 clear; bit 6 clear; or any of bits 14, 5 and 4 set. While `cfg_err` is 1, a strobe leaves `busy` at 0.
- R11: Latency code 2 with two-cycle hold and early WAIT (bit 8 set) raises `cfg_err`. Latency code 2 with two-cycle hold and bit 8 clear is legal and runs.
- R12: A strobe during a burst restarts from the new address with fresh latency under the live configuration. If the live configuration is in error at that strobe, the engine goes idle.
- R13: Changes to `cfg_word` during a burst do not alter that burst's timing, addresses or WAIT level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_n | input | 1 | Address strobe, active low |
| start_addr | input | AW | Starting word address, captured at a strobe |
| cfg_word | input | 16 | Read configuration word |
| mem_rdata | input | DW | Word returned by the array model for `mem_addr` |
| mem_addr | output | AW | Current word address on the read port |
| dout | output | DW | Data bus, zero when no word is valid |
| dvalid | output | 1 | High in every cycle that a word is presented |
| wait_o | output | 1 | WAIT, level set by configuration |
| busy | output | 1 | High while a burst is in progress |
| cfg_err | output | 1 | Live configuration is illegal or unsupported |

## Verification
The bench builds the block with its defaults, AW=16 and DW=16. A full 16-bit address space lets a linear burst started near 0xFFFC roll through zero, and lets wrapping windows of 8 and 16 words be placed just below a window boundary. The bench computes an expected per-cycle trace of `busy`, `dvalid`, WAIT, address and data. It does this for latency codes 2 through 7 across both hold settings, both WAIT timings and both polarities. It then places restarts, aborts and mid-burst configuration changes at fixed cycles within those traces.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int CFG_W = 16;

    // bit positions inside the configuration word
    localparam int B_PAGE    = 15;
    localparam int B_RSV_HI  = 14;
    localparam int B_LAT_HI  = 13;
    localparam int B_LAT_LO  = 11;
    localparam int B_WPOL    = 10;
    localparam int B_HOLD2   = 9;
    localparam int B_WEARLY  = 8;
    localparam int B_LINEAR  = 7;
    localparam int B_RISE    = 6;
    localparam int B_RSV_LO1 = 5;
    localparam int B_RSV_LO0 = 4;
    localparam int B_NOWRAP  = 3;
    localparam int B_LEN_HI  = 2;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'hBFCF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [2:0] lat;
        logic       wait_hi;
        logic       hold2;
        logic       wait_early;
        logic       no_wrap;
        logic       cont;
        logic [4:0] len;
    } burst_cfg_t;

    function automatic logic len_code_ok(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) ||
               (code == 3'b011) || (code == 3'b111);
    endfunction

    function automatic logic [4:0] len_words(input logic [2:0] code);
        logic [4:0] n;
        case (code)
            3'b001:  n = 5'd4;
            3'b010:  n = 5'd8;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

    function automatic burst_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        burst_cfg_t c;
        c.lat        = w[B_LAT_HI:B_LAT_LO];
        c.wait_hi    = w[B_WPOL];
        c.hold2      = w[B_HOLD2];
        c.wait_early = w[B_WEARLY];
        c.no_wrap    = w[B_NOWRAP];
        c.cont       = (w[B_LEN_HI:0] == 3'b111);
        c.len        = len_words(w[B_LEN_HI:0]);
        return c;
    endfunction

endpackage

// File: rtl/sbr_cfg_decode.sv
module sbr_cfg_decode
    import sbr_pkg::*;
(
    input  logic [CFG_W-1:0] word,
    output burst_cfg_t       cfg,
    output logic             page_mode,
    output logic             bad
);
    logic rsv_set;
    logic lat_bad;
    logic combo_bad;

    always_comb begin
        cfg       = unpack_cfg(word);
        page_mode = word[B_PAGE];
        rsv_set   = word[B_RSV_HI] | word[B_RSV_LO1] | word[B_RSV_LO0];
        lat_bad   = (word[B_LAT_HI:B_LAT_LO] < 3'd2);
        // shortest latency cannot host a WAIT lead of two clocks
        combo_bad = (word[B_LAT_HI:B_LAT_LO] == 3'd2) & word[B_HOLD2] & word[B_WEARLY];
        bad       = rsv_set | lat_bad | combo_bad | ~word[B_LINEAR] | ~word[B_RISE]
                  | ~len_code_ok(word[B_LEN_HI:0]);
    end

endmodule

// File: rtl/sbr_addr_gen.sv
module sbr_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] load_addr,
    input  logic          no_wrap,
    input  logic          cont,
    input  logic [4:0]    len,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] mask;
    logic [AW-1:0] nxt_lin;
    logic [AW-1:0] nxt_wrap;
    logic          wrap_en;

    always_comb begin
        mask     = AW'(len) - AW'(1);
        nxt_lin  = addr + AW'(1);
        nxt_wrap = (addr & ~mask) | (nxt_lin & mask);
        wrap_en  = ~no_wrap & ~cont;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            addr <= wrap_en ? nxt_wrap : nxt_lin;
        end
    end

endmodule

// File: rtl/sbr_seq_ctrl.sv
module sbr_seq_ctrl
    import sbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic [2:0] lat_new,
    input  logic [2:0] lat_q,
    input  logic       hold2_q,
    input  logic       early_q,
    input  logic       cont_q,
    input  logic [4:0] len_q,
    output logic       busy,
    output logic       dvalid,
    output logic       advance,
    output logic       wait_act
);
    seq_state_e st;
    logic [2:0] rem;
    logic       hsecond;
    logic [4:0] wcnt;
    logic [1:0] grp;

    logic       word_done;
    logic       last_word;
    logic       gap_due;
    logic [2:0] lead;

    always_comb begin
        word_done = (st == ST_DATA) && (!hold2_q || hsecond);
        last_word = !cont_q && (wcnt == len_q - 5'd1);
        gap_due   = !hold2_q && (lat_q > 3'd4) && (grp == 2'd3);
        lead      = early_q ? (hold2_q ? 3'd2 : 3'd1) : 3'd0;
        busy      = (st != ST_IDLE);
        dvalid    = (st == ST_DATA);
        advance   = word_done && !last_word;
        case (st)
            ST_LAT:  wait_act = (rem > lead);
            ST_DATA: wait_act = early_q && word_done && !last_word && gap_due;
            default: wait_act = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rem     <= '0;
            hsecond <= 1'b0;
            wcnt    <= '0;
            grp     <= '0;
        end else if (start) begin
            st      <= ST_LAT;
            rem     <= lat_new - 3'd1;
            hsecond <= 1'b0;
            wcnt    <= '0;
            grp     <= '0;
        end else if (abort) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_LAT: begin
                    if (rem == 3'd1) begin
                        st      <= ST_DATA;
                        hsecond <= 1'b0;
                    end else begin
                        rem <= rem - 3'd1;
                    end
                end
                ST_DATA: begin
                    if (!word_done) begin
                        hsecond <= 1'b1;
                    end else if (last_word) begin
                        st <= ST_IDLE;
                    end else begin
                        wcnt    <= wcnt + 5'd1;
                        grp     <= grp + 2'd1;
                        hsecond <= 1'b0;
                        if (gap_due) begin
                            st  <= ST_LAT;
                            rem <= lat_q - 3'd4;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sync_burst_reader.sv
module sync_burst_reader
    import sbr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_n,
    input  logic [AW-1:0]    start_addr,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    dout,
    output logic             dvalid,
    output logic             wait_o,
    output logic             busy,
    output logic             cfg_err
);
    burst_cfg_t cfg_live;
    burst_cfg_t cfg_q;
    logic       page_mode;
    logic       start;
    logic       abort;
    logic       advance;
    logic       wait_act;
    logic       pol;

    sbr_cfg_decode u_dec (
        .word      (cfg_word),
        .cfg       (cfg_live),
        .page_mode (page_mode),
        .bad       (cfg_err)
    );

    assign start = !adv_n && !page_mode && !cfg_err;
    assign abort = !adv_n && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= unpack_cfg(CFG_RESET);
        end else if (start) begin
            cfg_q <= cfg_live;
        end
    end

    sbr_seq_ctrl u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .lat_new  (cfg_live.lat),
        .lat_q    (cfg_q.lat),
        .hold2_q  (cfg_q.hold2),
        .early_q  (cfg_q.wait_early),
        .cont_q   (cfg_q.cont),
        .len_q    (cfg_q.len),
        .busy     (busy),
        .dvalid   (dvalid),
        .advance  (advance),
        .wait_act (wait_act)
    );

    sbr_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .step      (advance),
        .load_addr (start_addr),
        .no_wrap   (cfg_q.no_wrap),
        .cont      (cfg_q.cont),
        .len       (cfg_q.len),
        .addr      (mem_addr)
    );

    always_comb begin
        pol    = busy ? cfg_q.wait_hi : cfg_live.wait_hi;
        wait_o = wait_act ? pol : !pol;
        dout   = dvalid ? mem_rdata : '0;
    end

endmodule

// File: rtl/sync_burst_reader_chk.sv
module sync_burst_reader_chk (
    input logic        clk,
    input logic        rst,
    input logic        adv_n,
    input logic [15:0] cfg_word,
    input logic        cfg_err,
    input logic        busy,
    input logic        dvalid,
    input logic        wait_o
);
    // R10: a strobe under an erroneous configuration never starts a burst
    p_err_no_start_r10: assert property (@(posedge clk) disable iff (rst)
        (!adv_n && cfg_err) |=> !busy);

    // R2: page mode keeps the engine idle
    p_page_mode_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!adv_n && cfg_word[15]) |=> !busy);

    // R3: a legal strobe opens a latency phase, never data at once
    p_start_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (!adv_n && !cfg_word[15] && !cfg_err) |=> (busy && !dvalid));

    // R8: while idle WAIT sits at the inactive level of the live polarity
    p_idle_wait_level_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (wait_o == !cfg_word[10]));

    // R5: without a strobe, a burst only ends right after a data cycle
    p_end_after_word_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(adv_n)) |-> $past(dvalid));

endmodule

bind sync_burst_reader sync_burst_reader_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .adv_n    (adv_n),
    .cfg_word (cfg_word),
    .cfg_err  (cfg_err),
    .busy     (busy),
    .dvalid   (dvalid),
    .wait_o   (wait_o)
);

// File: tb/tb_sync_burst_reader.sv
`timescale 1ns/1ps
module tb_sync_burst_reader;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NA = 160;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic [15:0]   cfg_word = 16'hBFCF;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] dout;
    logic          dvalid, wait_o, busy, cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sync_burst_reader #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .adv_n(adv_n), .start_addr(start_addr),
        .cfg_word(cfg_word), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .dout(dout), .dvalid(dvalid), .wait_o(wait_o), .busy(busy), .cfg_err(cfg_err)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + 8'h21};
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    function automatic logic [15:0] mk_cfg(input logic [2:0] lat, input logic hold2,
        input logic early, input logic pol, input logic nowrap, input logic [2:0] bl);
        return {1'b0, 1'b0, lat, pol, hold2, early, 1'b1, 1'b1, 2'b00, nowrap, bl};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Builds the expected per-cycle trace from the requirements, then
    // strobes and compares cycles 1..ncyc after the sampling edge.
    task automatic run_trace(input logic [15:0] cfg, input logic [15:0] addr,
        input int ncyc, input int mid_k, input logic [15:0] mid_cfg, input string req);
        bit s[NA];
        bit v[NA];
        bit b[NA];
        logic [15:0] a[NA];
        logic [15:0] wa;
        logic [15:0] msk;
        int lat, hold, lead, blen, k;
        bit h2, pol, cont, wrapw, act, lvl;
        for (int i = 0; i < NA; i++) begin
            s[i] = 0; v[i] = 0; b[i] = 0; a[i] = '0;
        end
        lat  = int'(cfg[13:11]);
        h2   = cfg[9];
        hold = h2 ? 2 : 1;
        lead = cfg[8] ? hold : 0;
        pol  = cfg[10];
        cont = 0;
        case (cfg[2:0])
            3'b001:  blen = 4;
            3'b010:  blen = 8;
            3'b011:  blen = 16;
            default: begin blen = 16; cont = 1; end
        endcase
        wrapw = !cfg[3] && !cont;
        msk   = 16'(blen - 1);
        k = 1;
        for (int i = 1; i < lat; i++) begin
            s[k] = 1; b[k] = 1; k++;
        end
        for (int w = 0; k <= ncyc; w++) begin
            wa = wrapw ? ((addr & ~msk) | ((addr + 16'(w)) & msk)) : (addr + 16'(w));
            for (int h = 0; h < hold; h++) begin
                if (k < NA) begin v[k] = 1; b[k] = 1; a[k] = wa; end
                k++;
            end
            if (!cont && w == blen - 1) break;
            if (!h2 && lat > 4 && (w % 4) == 3) begin
                for (int g = 0; g < lat - 4; g++) begin
                    if (k < NA) begin s[k] = 1; b[k] = 1; end
                    k++;
                end
            end
        end

        @(negedge clk);
        cfg_word   = cfg;
        start_addr = addr;
        adv_n      = 1'b0;
        @(negedge clk);
        adv_n = 1'b1;
        for (int c = 1; c <= ncyc; c++) begin
            if (c > 1) @(negedge clk);
            act = b[c] && s[c + lead];
            lvl = b[c] ? pol : cfg_word[10];
            chk(req, $sformatf("busy c%0d", c), int'(busy), int'(b[c]));
            chk(req, $sformatf("dvalid c%0d", c), int'(dvalid), int'(v[c]));
            chk(req, $sformatf("wait c%0d", c), int'(wait_o), int'(act ? lvl : !lvl));
            if (v[c]) begin
                chk(req, $sformatf("addr c%0d", c), int'(mem_addr), int'(a[c]));
                chk(req, $sformatf("dout c%0d", c), int'(dout), int'(mem_word(a[c])));
            end else begin
                chk(req, $sformatf("dout idle c%0d", c), int'(dout), 0);
            end
            if (c == mid_k) cfg_word = mid_cfg;
        end
    endtask

    task automatic t_reset();
        // R1: state held in and right after reset
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "dvalid", int'(dvalid), 0);
        chk("R1", "dout", int'(dout), 0);
        chk("R1", "cfg_err", int'(cfg_err), 0);
        chk("R1", "wait", int'(wait_o), 0);
    endtask

    task automatic t_page_mode();
        // R2: strobe in page mode starts nothing
        @(negedge clk);
        cfg_word = 16'hBFCF;
        adv_n = 1'b0;
        @(negedge clk);
        adv_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R2", "busy page mode", int'(busy), 0);
            chk("R2", "dvalid page mode", int'(dvalid), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_bad_cfg(input logic [15:0] bad, input string req);
        @(negedge clk);
        cfg_word = bad;
        adv_n = 1'b0;
        #1;
        chk(req, "cfg_err", int'(cfg_err), 1);
        @(negedge clk);
        adv_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk(req, "busy on bad cfg", int'(busy), 0);
            chk(req, "wait on bad cfg", int'(wait_o), int'(!bad[10]));
            @(negedge clk);
        end
    endtask

    task automatic t_errors();
        // R10: each illegal field on its own
        t_bad_cfg(mk_cfg(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001), "R10 lat1");
        t_bad_cfg(mk_cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001), "R10 lat0");
        t_bad_cfg(mk_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 3'b100), "R10 len100");
        t_bad_cfg(mk_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001) & ~16'h0080, "R10 seq bit7");
        t_bad_cfg(mk_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001) & ~16'h0040, "R10 edge bit6");
        t_bad_cfg(mk_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001) | 16'h4000, "R10 rsv bit14");
        t_bad_cfg(mk_cfg(3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001) | 16'h0010, "R10 rsv bit4");
        // R11: unsupported short-latency combination
        t_bad_cfg(mk_cfg(3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 3'b001), "R11 combo");
    endtask

    task automatic t_basic();
        // R3 R4 R5: latency 4, one-clock hold, 4 words, linear
        run_trace(mk_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001), 16'h0040, 12, 0, 16'h0, "R3/R4/R5");
    endtask

    task automatic t_gaps_wrap16();
        // R6 R7 R9: latency 7, early WAIT, 16-word wrap window
        run_trace(mk_cfg(3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 3'b011), 16'h123A, 36, 0, 16'h0, "R6/R7/R9");
    endtask

    task automatic t_hold2_low();
        // R4 R7 R8: two-clock hold, active-low WAIT, 8-word wrap
        run_trace(mk_cfg(3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 3'b010), 16'h0FFE, 24, 0, 16'h0, "R4/R7/R8");
    endtask

    task automatic t_continuous();
        // R6: unbounded burst runs linearly through the top of the space
        run_trace(mk_cfg(3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111), 16'hFFFC, 30, 0, 16'h0, "R6 cont");
        // R2: page-mode strobe ends the running burst
        @(negedge clk);
        cfg_word = 16'hBFCF;
        adv_n = 1'b0;
        @(negedge clk);
        adv_n = 1'b1;
        chk("R2", "busy after page-mode strobe", int'(busy), 0);
        chk("R2", "dvalid after page-mode strobe", int'(dvalid), 0);
    endtask

    task automatic t_short_lat();
        // R3 R9: latency 2 with early WAIT and one-clock hold
        run_trace(mk_cfg(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 3'b001), 16'h0100, 8, 0, 16'h0, "R3/R9 lat2");
        // R11: latency 2, two-clock hold, WAIT with data is legal
        run_trace(mk_cfg(3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'b001), 16'h0200, 12, 0, 16'h0, "R11 legal");
    endtask

    task automatic t_restart();
        // R12: second strobe mid-burst restarts from a new address
        run_trace(mk_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 3'b111), 16'h2000, 6, 0, 16'h0, "R12 first");
        run_trace(mk_cfg(3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 3'b010), 16'h3005, 16, 0, 16'h0, "R12 restart");
        // R12: strobe with an erroneous configuration aborts to idle
        run_trace(mk_cfg(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 3'b111), 16'h4000, 5, 0, 16'h0, "R12 pre-abort");
        @(negedge clk);
        cfg_word = mk_cfg(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001);
        adv_n = 1'b0;
        @(negedge clk);
        adv_n = 1'b1;
        chk("R12", "busy after bad strobe", int'(busy), 0);
        chk("R12", "wait after bad strobe", int'(wait_o), 0);
    endtask

    task automatic t_mid_change();
        // R13: configuration rewritten during the latency phase
        run_trace(mk_cfg(3'd6, 1'b0, 1'b1, 1'b1, 1'b1, 3'b011), 16'h0510, 30, 3,
                  mk_cfg(3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'b001), "R13");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL [watchdog] run did not finish: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_page_mode();
        t_basic();
        t_gaps_wrap16();
        t_hold2_low();
        t_continuous();
        t_short_lat();
        t_errors();
        t_restart();
        t_mid_change();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule